// File: doc/BRIEF.md
# L1 Data Cache Access Controller

This block makes the per-cycle access decision for a first-level data cache. A request carries an address, a read/write flag, an atomic flag and a global/local access type. The block probes a set-associative tag array and answers in the same cycle with HIT, MISS or FAIL. At the next clock edge it updates line status and LRU ages, and it pushes any outgoing requests into a bounded miss queue. A small miss-tracking table merges repeated read misses to a block that is already pending.

The write policy depends on the access type. A global write that hits is forwarded downward and invalidates the line. A local write that hits marks the line dirty, unless the evict-on-write configuration input is set, in which case every write hit is forwarded and invalidates the line. A write that misses is forwarded with no allocation. A fill port models the return of the lower level: it releases the matching tracking entry and makes the reserved line valid. The data array and the lower memory are outside this block.

Top module: `l1d_access_ctrl`

## Requirements
- R1: A write that hits a valid or dirty line with req_global=1 returns HIT, queues one entry of kind 1 (write) holding the full request address with full-line flag 0, and leaves that line invalid so that a later read of it misses.
- R2: A write that hits with req_global=0 while cfg_write_evict=0 returns HIT, queues nothing, makes the line dirty and refreshes its LRU age.
- R3: With cfg_write_evict=1, every write hit takes the R1 path, whatever the access type.
- R4: A write that misses (including a hit on a reserved line) needs one free queue slot. It returns MISS, queues only the write, and allocates no line. With no free slot it returns FAIL.
- R5: A read hit returns HIT and refreshes the LRU age. When req_atomic=1 the line also becomes dirty, so its later eviction produces a writeback.
- R6: A read miss needs at least two free queue slots. With fewer it returns FAIL and changes no state.
- R7: A read miss to a block with no tracking entry allocates an entry, reserves a victim way under the new tag, queues a read of kind 0 with the block-aligned address and full-line flag 1, and returns MISS. If the victim is dirty, a writeback of kind 2 with the victim's block-aligned address and full-line flag 1 is queued right after the read.
- R8: A read miss to a block with a pending entry merges into it (MISS, nothing queued) while the entry holds fewer than MSHR_MERGE requests. Otherwise it returns FAIL. A new block with every tracking entry busy also returns FAIL.
- R9: A write hit on the forward-and-invalidate path with a full queue returns FAIL and leaves the line valid.
- R10: Victim choice takes the lowest-numbered invalid way first, and otherwise the least recently used way among valid or dirty lines. Reserved lines are never chosen, and a read miss whose set holds only reserved lines returns FAIL.
- R11: A fill releases the tracking entry for its block and makes the reserved line valid, so that a following read of that block hits. A request presented in the same cycle as a fill returns FAIL and has no effect.
- R12: The miss queue holds MQ_DEPTH entries and presents them in push order on a valid/ready port. It never holds more than MQ_DEPTH entries.
- R13: rsp_status encodes 0 for no request, 1 for HIT, 2 for MISS and 3 for FAIL. After reset all lines are invalid and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_write_evict | input | 1 | Forward and invalidate on every write hit |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_atomic | input | 1 | Atomic read: dirty the line on hit |
| req_global | input | 1 | 1 for global access type, 0 for local |
| rsp_status | output | 2 | 0 idle, 1 HIT, 2 MISS, 3 FAIL (combinational) |
| mq_valid | output | 1 | Miss queue head is valid |
| mq_ready | input | 1 | Consumer takes the head entry |
| mq_addr | output | ADDR_W | Head entry address |
| mq_kind | output | 2 | 0 read, 1 write, 2 writeback |
| mq_full_line | output | 1 | Head entry covers a whole line |
| fill_valid | input | 1 | Fill returns for a pending block |
| fill_addr | input | ADDR_W | Address of the filled block (offset ignored) |

## Verification
The bench goes after the eviction order first. If the LRU ages were mishandled, or a dirty mark from an atomic read were lost, the wrong victim would be chosen or the writeback would be missing or out of order behind the read. It then fills the queue to one short of full and to full. A design that counted one slot for a read miss, or that let a forwarded write hit through a full queue, would queue an extra entry or drop the line. It also pushes the tracking table to its merge limit, to its entry limit and to a set that holds only reserved lines, where a wrong design would accept the request or evict a line still waiting for its fill. A request that collides with a fill must fail with no side effect.

// File: rtl/l1d_access_ctrl.sv
module l1d_access_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int OFF_W      = 2,
  parameter int SET_W      = 2,
  parameter int WAYS       = 4,
  parameter int MQ_DEPTH   = 8,
  parameter int MSHR_N     = 4,
  parameter int MSHR_MERGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_write_evict,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_atomic,
  input  logic              req_global,
  output logic [1:0]        rsp_status,
  output logic              mq_valid,
  input  logic              mq_ready,
  output logic [ADDR_W-1:0] mq_addr,
  output logic [1:0]        mq_kind,
  output logic              mq_full_line,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr
);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int MQ_AW = $clog2(MQ_DEPTH);
  localparam int MQ_CW = $clog2(MQ_DEPTH + 1);
  localparam int MC_W  = $clog2(MSHR_MERGE + 1);
  localparam int MI_W  = $clog2(MSHR_N);
  localparam logic [1:0] ST_INV = 2'd0, ST_VAL = 2'd1, ST_MOD = 2'd2, ST_RSV = 2'd3;
  localparam logic [1:0] RS_IDLE = 2'd0, RS_HIT = 2'd1, RS_MISS = 2'd2, RS_FAIL = 2'd3;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;

  logic [1:0]       st  [SETS][WAYS];
  logic [TAG_W-1:0] tg  [SETS][WAYS];
  logic [WAY_W-1:0] age [SETS][WAYS];
  logic             m_v   [MSHR_N];
  logic [BLK_W-1:0] m_blk [MSHR_N];
  logic [MC_W-1:0]  m_cnt [MSHR_N];
  logic [ADDR_W-1:0] q_a [MQ_DEPTH];
  logic [1:0]        q_k [MQ_DEPTH];
  logic              q_f [MQ_DEPTH];
  logic [MQ_AW-1:0]  rd_p, wr_p;
  logic [MQ_CW-1:0]  mq_cnt;

  wire [BLK_W-1:0] blk  = req_addr[ADDR_W-1:OFF_W];
  wire [SET_W-1:0] s    = blk[SET_W-1:0];
  wire [TAG_W-1:0] t    = blk[BLK_W-1:SET_W];
  wire [BLK_W-1:0] fblk = fill_addr[ADDR_W-1:OFF_W];
  wire [SET_W-1:0] fs   = fblk[SET_W-1:0];
  wire [MQ_CW-1:0] free = MQ_CDEPTH() - mq_cnt;
  wire             mq_pop = mq_valid && mq_ready;

  function automatic logic [MQ_CW-1:0] MQ_CDEPTH();
    return MQ_CW'(MQ_DEPTH);
  endfunction

  assign mq_valid     = mq_cnt != '0;
  assign mq_addr      = q_a[rd_p];
  assign mq_kind      = q_k[rd_p];
  assign mq_full_line = q_f[rd_p];

  logic [WAYS-1:0]  hv;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             inv_ok, old_ok;
  logic [WAY_W-1:0] inv_way, old_way, old_age;
  always_comb begin
    hv = '0; hit_way = '0;
    inv_ok = 1'b0; inv_way = '0; old_ok = 1'b0; old_way = '0; old_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      hv[w] = (st[s][w] == ST_VAL || st[s][w] == ST_MOD) && tg[s][w] == t;
      if (hv[w]) hit_way = WAY_W'(w);
      if (st[s][w] == ST_INV && !inv_ok) begin
        inv_ok = 1'b1; inv_way = WAY_W'(w);
      end
      if ((st[s][w] == ST_VAL || st[s][w] == ST_MOD) && (!old_ok || age[s][w] > old_age)) begin
        old_ok = 1'b1; old_way = WAY_W'(w); old_age = age[s][w];
      end
    end
    hit = |hv;
  end
  wire             vic_ok    = inv_ok || old_ok;
  wire [WAY_W-1:0] vic_way   = inv_ok ? inv_way : old_way;
  wire             vic_dirty = !inv_ok && st[s][old_way] == ST_MOD;

  logic            m_hit, m_free;
  logic [MI_W-1:0] m_hi, m_fi;
  always_comb begin
    m_hit = 1'b0; m_free = 1'b0; m_hi = '0; m_fi = '0;
    for (int i = 0; i < MSHR_N; i++) begin
      if (m_v[i] && m_blk[i] == blk) begin m_hit = 1'b1; m_hi = MI_W'(i); end
      if (!m_v[i] && !m_free) begin m_free = 1'b1; m_fi = MI_W'(i); end
    end
  end

  logic             p0, p1, upd, tch, alloc, merge;
  logic [1:0]       p0_k, upd_st;
  logic             p0_f;
  logic [ADDR_W-1:0] p0_a, p1_a;
  logic [WAY_W-1:0] upd_way;
  always_comb begin
    rsp_status = RS_IDLE;
    p0 = 1'b0; p1 = 1'b0; p0_k = K_WR; p0_f = 1'b0; p0_a = req_addr;
    p1_a = {tg[s][old_way], s, {OFF_W{1'b0}}};
    upd = 1'b0; upd_st = ST_VAL; upd_way = hit_way; tch = 1'b0; alloc = 1'b0; merge = 1'b0;
    if (req_valid) begin
      if (fill_valid) rsp_status = RS_FAIL;
      else if (req_write) begin
        if (hit && (req_global || cfg_write_evict)) begin
          if (free != '0) begin
            rsp_status = RS_HIT; p0 = 1'b1; upd = 1'b1; upd_st = ST_INV;
          end else rsp_status = RS_FAIL;
        end else if (hit) begin
          rsp_status = RS_HIT; upd = 1'b1; upd_st = ST_MOD; tch = 1'b1;
        end else if (free != '0) begin
          rsp_status = RS_MISS; p0 = 1'b1;
        end else rsp_status = RS_FAIL;
      end else if (hit) begin
        rsp_status = RS_HIT; tch = 1'b1;
        if (req_atomic) begin upd = 1'b1; upd_st = ST_MOD; end
      end else if (free < MQ_CW'(2)) rsp_status = RS_FAIL;
      else if (m_hit) begin
        if (m_cnt[m_hi] < MC_W'(MSHR_MERGE)) begin rsp_status = RS_MISS; merge = 1'b1; end
        else rsp_status = RS_FAIL;
      end else if (m_free && vic_ok) begin
        rsp_status = RS_MISS; alloc = 1'b1; tch = 1'b1;
        upd = 1'b1; upd_st = ST_RSV; upd_way = vic_way;
        p0 = 1'b1; p0_k = K_RD; p0_f = 1'b1; p0_a = {blk, {OFF_W{1'b0}}};
        p1 = vic_dirty;
      end else rsp_status = RS_FAIL;
    end
  end
  wire [WAY_W-1:0] tch_way = alloc ? vic_way : hit_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < SETS; a++)
        for (int w = 0; w < WAYS; w++) begin
          st[a][w] <= ST_INV; tg[a][w] <= '0; age[a][w] <= WAY_W'(w);
        end
      for (int i = 0; i < MSHR_N; i++) begin
        m_v[i] <= 1'b0; m_blk[i] <= '0; m_cnt[i] <= '0;
      end
      rd_p <= '0; wr_p <= '0; mq_cnt <= '0;
    end else begin
      if (fill_valid) begin
        for (int i = 0; i < MSHR_N; i++)
          if (m_v[i] && m_blk[i] == fblk) m_v[i] <= 1'b0;
        for (int w = 0; w < WAYS; w++)
          if (st[fs][w] == ST_RSV && tg[fs][w] == fblk[BLK_W-1:SET_W]) st[fs][w] <= ST_VAL;
      end
      if (upd) st[s][upd_way] <= upd_st;
      if (alloc) begin
        tg[s][vic_way] <= t;
        m_v[m_fi] <= 1'b1; m_blk[m_fi] <= blk; m_cnt[m_fi] <= MC_W'(1);
      end
      if (merge) m_cnt[m_hi] <= m_cnt[m_hi] + MC_W'(1);
      if (tch)
        for (int w = 0; w < WAYS; w++)
          if (age[s][w] < age[s][tch_way]) age[s][w] <= age[s][w] + WAY_W'(1);
          else if (WAY_W'(w) == tch_way) age[s][w] <= '0;
      if (p0) begin
        q_a[wr_p] <= p0_a; q_k[wr_p] <= p0_k; q_f[wr_p] <= p0_f;
      end
      if (p1) begin
        q_a[wr_p + MQ_AW'(1)] <= p1_a; q_k[wr_p + MQ_AW'(1)] <= K_WB; q_f[wr_p + MQ_AW'(1)] <= 1'b1;
      end
      wr_p   <= wr_p + MQ_AW'(p0) + MQ_AW'(p1);
      rd_p   <= rd_p + MQ_AW'(mq_pop);
      mq_cnt <= mq_cnt + MQ_CW'(p0) + MQ_CW'(p1) - MQ_CW'(mq_pop);
    end
  end

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) mq_cnt <= MQ_CDEPTH());
  a_r10_single_hit: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hv));
  a_r6_fail_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_status == RS_FAIL) |=> mq_cnt == $past(mq_cnt) - MQ_CW'($past(mq_pop)));
  a_r4_write_miss_one: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && rsp_status == RS_MISS) |=> mq_cnt == $past(mq_cnt) + MQ_CW'(1) - MQ_CW'($past(mq_pop)));
  a_r2_local_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_global && !cfg_write_evict && rsp_status == RS_HIT)
    |=> mq_cnt == $past(mq_cnt) - MQ_CW'($past(mq_pop)));
  a_r11_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fill_valid) |-> rsp_status == RS_FAIL);
  generate
    for (genvar g = 0; g < MSHR_N; g++) begin : g_mchk
      a_r8_merge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        m_v[g] |-> (m_cnt[g] <= MC_W'(MSHR_MERGE) && m_cnt[g] != '0));
    end
  endgenerate
endmodule

// File: tb/sim_l1d_access_ctrl.sv
module sim_l1d_access_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cfg_write_evict = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_atomic = 1'b0, req_global = 1'b0;
  logic [11:0] req_addr = '0, fill_addr = '0;
  logic mq_ready = 1'b0, fill_valid = 1'b0;
  logic [1:0] rsp_status, mq_kind;
  logic mq_valid, mq_full_line;
  logic [11:0] mq_addr;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  localparam logic [1:0] HIT = 2'd1, MISS = 2'd2, FAIL = 2'd3;

  always #4 clk = ~clk;

  l1d_access_ctrl #(.ADDR_W(12), .OFF_W(2), .SET_W(2), .WAYS(4), .MQ_DEPTH(8),
                    .MSHR_N(5), .MSHR_MERGE(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_write_evict(cfg_write_evict), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_atomic(req_atomic), .req_global(req_global),
    .rsp_status(rsp_status), .mq_valid(mq_valid), .mq_ready(mq_ready), .mq_addr(mq_addr),
    .mq_kind(mq_kind), .mq_full_line(mq_full_line), .fill_valid(fill_valid), .fill_addr(fill_addr));

  function automatic logic [11:0] ad(input int tag, input int set, input int off);
    return {8'(tag), 2'(set), 2'(off)};
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input bit glb, input bit atm, input logic [11:0] a,
                     input logic [1:0] exp, input string r, input bit with_fill = 1'b0,
                     input logic [11:0] fa = '0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_global = glb; req_atomic = atm; req_addr = a;
    fill_valid = with_fill; fill_addr = fa;
    #1 check(r, 32'(rsp_status), 32'(exp));
    @(posedge clk); #1;
    req_valid = 1'b0; req_atomic = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic pop(input logic [1:0] k, input logic [11:0] a, input bit f, input string r);
    @(negedge clk);
    check({r, " valid"}, 32'(mq_valid), 1);
    check({r, " kind"}, 32'(mq_kind), 32'(k));
    check({r, " addr"}, 32'(mq_addr), 32'(a));
    check({r, " full"}, 32'(mq_full_line), 32'(f));
    mq_ready = 1'b1;
    @(posedge clk); #1 mq_ready = 1'b0;
  endtask

  task automatic empty(input string r);
    @(negedge clk);
    check({r, " queue empty"}, 32'(mq_valid), 0);
  endtask

  task automatic fill(input logic [11:0] a);
    @(negedge clk); fill_valid = 1'b1; fill_addr = a;
    @(posedge clk); #1 fill_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R13 idle status", 32'(rsp_status), 0);
    check("R13 queue empty after reset", 32'(mq_valid), 0);

    // read miss, merge, merge limit, fill, hit, local write hit
    acc(0, 1, 0, ad(1, 0, 0), MISS, "R7 first read miss");
    pop(2'd0, ad(1, 0, 0), 1, "R7 read request");
    acc(0, 1, 0, ad(1, 0, 2), MISS, "R8 merge");
    empty("R8 merge sends nothing");
    acc(0, 1, 0, ad(1, 0, 0), FAIL, "R8 merge limit");
    fill(ad(1, 0, 0));
    acc(0, 1, 0, ad(1, 0, 0), HIT, "R11 hit after fill");
    acc(1, 0, 0, ad(1, 0, 1), HIT, "R2 local write hit");
    empty("R2 no request");

    // fill set 0, evict dirty LRU line
    for (int k = 2; k <= 4; k++) begin
      acc(0, 1, 0, ad(k, 0, 0), MISS, "R7 fill set0");
      pop(2'd0, ad(k, 0, 0), 1, "R7 read");
      fill(ad(k, 0, 0));
    end
    acc(0, 1, 0, ad(5, 0, 0), MISS, "R10 evict LRU");
    pop(2'd0, ad(5, 0, 0), 1, "R7 read before writeback");
    pop(2'd2, ad(1, 0, 0), 1, "R7 dirty victim writeback");
    empty("R7 only two entries");
    fill(ad(5, 0, 0));

    // global write hit evicts
    acc(1, 1, 0, ad(2, 0, 1), HIT, "R1 global write hit");
    pop(2'd1, ad(2, 0, 1), 0, "R1 forwarded write");
    acc(0, 1, 0, ad(2, 0, 0), MISS, "R1 line invalidated");
    pop(2'd0, ad(2, 0, 0), 1, "R10 reuse invalid way");
    empty("R10 invalid victim no writeback");
    fill(ad(2, 0, 0));

    // configured evict on local write hit
    cfg_write_evict = 1'b1;
    acc(1, 0, 0, ad(3, 0, 3), HIT, "R3 local write hit under evict");
    pop(2'd1, ad(3, 0, 3), 0, "R3 forwarded write");
    cfg_write_evict = 1'b0;
    acc(0, 1, 0, ad(3, 0, 0), MISS, "R3 line invalidated");
    pop(2'd0, ad(3, 0, 0), 1, "R3 reread");
    fill(ad(3, 0, 0));

    // write miss without allocation
    acc(1, 1, 0, ad(9, 0, 2), MISS, "R4 write miss");
    pop(2'd1, ad(9, 0, 2), 0, "R4 write only");
    empty("R4 single entry");
    acc(0, 1, 0, ad(9, 0, 0), MISS, "R4 no allocation");
    pop(2'd0, ad(9, 0, 0), 1, "R4 read after write miss");
    empty("R10 clean victim");
    fill(ad(9, 0, 0));

    // atomic read dirties line (set 1)
    for (int k = 1; k <= 4; k++) acc(0, 1, 0, ad(k, 1, 0), MISS, "R7 set1 miss");
    for (int k = 1; k <= 4; k++) pop(2'd0, ad(k, 1, 0), 1, "R7 set1 read");
    for (int k = 1; k <= 4; k++) fill(ad(k, 1, 0));
    acc(0, 1, 1, ad(1, 1, 0), HIT, "R5 atomic read hit");
    for (int k = 2; k <= 4; k++) acc(0, 1, 0, ad(k, 1, 0), HIT, "R5 read hit");
    acc(0, 1, 0, ad(5, 1, 0), MISS, "R5 evict atomic line");
    pop(2'd0, ad(5, 1, 0), 1, "R5 read");
    pop(2'd2, ad(1, 1, 0), 1, "R5 atomic dirty writeback");
    fill(ad(5, 1, 0));
    acc(0, 1, 0, ad(6, 1, 0), MISS, "R10 next LRU clean");
    pop(2'd0, ad(6, 1, 0), 1, "R10 read");
    empty("R5 plain read leaves line clean");
    fill(ad(6, 1, 0));

    // all ways reserved, tracking table full, fill collision
    for (int k = 7; k <= 10; k++) begin
      acc(0, 1, 0, ad(k, 1, 0), MISS, "R10 reserve way");
      pop(2'd0, ad(k, 1, 0), 1, "R10 read");
    end
    acc(0, 1, 0, ad(11, 1, 0), FAIL, "R10 all ways reserved");
    acc(0, 1, 0, ad(1, 2, 0), MISS, "R8 last tracking entry");
    pop(2'd0, ad(1, 2, 0), 1, "R8 read");
    acc(0, 1, 0, ad(2, 3, 0), FAIL, "R8 tracking table full");
    empty("R8 no request on fail");
    acc(0, 1, 0, ad(7, 1, 0), FAIL, "R11 request during fill", 1'b1, ad(7, 1, 0));
    empty("R11 collided request no effect");
    for (int k = 8; k <= 10; k++) fill(ad(k, 1, 0));
    fill(ad(1, 2, 0));
    acc(0, 1, 0, ad(7, 1, 0), HIT, "R11 fill made line valid");
    acc(0, 1, 0, ad(1, 2, 0), HIT, "R11 fill set2");

    // queue capacity
    acc(0, 1, 0, ad(3, 3, 0), MISS, "R7 line G");
    pop(2'd0, ad(3, 3, 0), 1, "R7 line G read");
    fill(ad(3, 3, 0));
    for (int k = 20; k <= 26; k++) acc(1, 1, 0, ad(k, 3, 1), MISS, "R4 fill queue");
    acc(0, 1, 0, ad(30, 3, 0), FAIL, "R6 one slot left");
    acc(1, 1, 0, ad(27, 3, 1), MISS, "R4 last slot");
    acc(1, 1, 0, ad(28, 3, 1), FAIL, "R4 queue full");
    acc(1, 1, 0, ad(3, 3, 2), FAIL, "R9 evict path queue full");
    for (int k = 20; k <= 27; k++) pop(2'd1, ad(k, 3, 1), 0, "R12 push order");
    empty("R12 drained");
    acc(0, 1, 0, ad(3, 3, 0), HIT, "R9 line kept");
    acc(0, 1, 0, ad(30, 3, 0), MISS, "R6 failed miss left no tracking entry");
    pop(2'd0, ad(30, 3, 0), 1, "R6 read");

    done = 1'b1;
    summary();
  end
endmodule